// File: doc/BRIEF.md
# Level-Mapped Interrupt Controller

This block gathers eight level-sensitive interrupt sources and presents them to a processor as sixteen per-priority request lines. Each source is tied to a fixed priority level by a sparse table. A request line is high exactly while at least one active, valid source maps to its level. Two source positions map to level zero, which the processor never services. Those two sources are discarded and can never raise a line.

A single byte-wide control register sits behind a chip-select on a simple memory-mapped port. A write stores the data byte with bit 6 forced to zero. A read returns the stored byte in the same cycle as the select, with no wait states. Bit 0 of the register is a global enable. While it is clear, every request line is held low, but the masked source state still follows the inputs. Setting the bit again makes the current sources visible on the next cycle.

All request lines are registered. They change one clock edge after the source change or the register write that caused the change.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x01 and all sixteen request lines are low.
- R2: While bus_cs is high, bus_rdata equals the stored control byte in the same cycle, with no clock edge needed. While bus_cs is low, bus_rdata is 0x00.
- R3: A write (bus_cs and bus_we high at a clock edge) stores bus_wdata AND 0xBF, so bit 6 always reads back as 0.
- R4: Source bit i maps to request line L(i), where L = {0,1,4,6,8,10,0,14} for i = 0..7. For example, source 5 drives irq_lvl[10].
- R5: Source bits 0 and 6 (level 0) have no effect on any request line, whether they are high alone or together with other sources.
- R6: Sources are level-sensitive. A request line stays high while its source is high and goes low after the source falls.
- R7: Several sources that are high together raise all of their lines at once. With all eight sources high and the enable set, irq_lvl is 0x4552.
- R8: With control bit 0 clear, all request lines are low, and sources that change meanwhile are still tracked. After bit 0 is written back to 1, the lines show the current sources on the next cycle.
- R9: Request lines change at the first clock edge after a source change or a register write, and not before that edge.
- R10: irq_lvl[0] is always low.
- R11: bus_we without bus_cs has no effect on the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip-select for the control byte |
| bus_we | input | 1 | Write strobe, valid with bus_cs |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the select |
| src_in | input | 8 | Level-sensitive interrupt sources |
| irq_lvl | output | 16 | Registered per-level request lines |

## Verification
The mapping is checked first with one source at a time, walking all eight positions. This tells a wrong table entry apart from a wrong OR across sources. A pattern with every source high and a pattern with only the two level-zero sources high separate correct discarding from leakage onto line 0 or onto some other line. A source that is raised and then dropped, sampled just before and just after the edge, separates level-following and one-cycle timing from latching or extra delay. A sequence that disables the block, changes the sources and then re-enables it shows that the source state kept tracking while the lines were held low.

// File: rtl/lic_pkg.sv
package lic_pkg;

    localparam int unsigned SRC_N  = 8;
    localparam int unsigned LVL_N  = 16;
    localparam int unsigned DATA_W = 8;

    // bit 6 of the control byte is never stored
    localparam logic [DATA_W-1:0] WR_KEEP   = 8'hBF;
    localparam logic [DATA_W-1:0] CTRL_INIT = 8'h01;
    localparam int unsigned       EN_BIT    = 0;

    typedef struct packed {
        logic              wr;
        logic [DATA_W-1:0] data;
    } ctrl_wr_t;

    typedef struct packed {
        logic [DATA_W-1:0] cur;
        logic [DATA_W-1:0] nxt;
    } ctrl_state_t;

    // fixed priority level of each source position
    function automatic int unsigned src_level(input int unsigned idx);
        case (idx)
            1:       return 1;
            2:       return 4;
            3:       return 6;
            4:       return 8;
            5:       return 10;
            7:       return 14;
            default: return 0;
        endcase
    endfunction

    // sources that reach a serviceable level
    function automatic logic [SRC_N-1:0] valid_srcs();
        logic [SRC_N-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < SRC_N; i++)
            if (src_level(i) != 0) m[i] = 1'b1;
        return m;
    endfunction

    // sources that feed a given level (level 0 feeds nothing)
    function automatic logic [SRC_N-1:0] level_members(input int unsigned lvl);
        logic [SRC_N-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < SRC_N; i++)
            if (lvl != 0 && src_level(i) == lvl) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/lic_ctrl_reg.sv
module lic_ctrl_reg
    import lic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ctrl_wr_t    wr,
    output ctrl_state_t st
);
    logic [DATA_W-1:0] ctrl_r;

    always_comb begin
        st.cur = ctrl_r;
        st.nxt = wr.wr ? (wr.data & WR_KEEP) : ctrl_r;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_r <= CTRL_INIT;
        else     ctrl_r <= st.nxt;
    end
endmodule

// File: rtl/lic_src_filter.sv
module lic_src_filter
    import lic_pkg::*;
#(
    parameter int unsigned N = SRC_N
) (
    input  logic [N-1:0] src_in,
    output logic [N-1:0] pend
);
    localparam logic [N-1:0] KEEP = valid_srcs();

    // pending follows the valid sources level for level
    always_comb pend = src_in & KEEP;
endmodule

// File: rtl/lic_lvl_out.sv
module lic_lvl_out
    import lic_pkg::*;
#(
    parameter int unsigned N = SRC_N,
    parameter int unsigned L = LVL_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    input  logic         enable,
    output logic [L-1:0] irq_q
);
    logic [L-1:0] irq_d;

    for (genvar g = 0; g < L; g++) begin : g_lvl
        if (g == 0) begin : g_zero
            always_comb irq_d[g] = 1'b0;
        end else begin : g_map
            localparam logic [N-1:0] MEMB = level_members(g);
            always_comb irq_d[g] = enable & (|(pend & MEMB));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_d;
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  src_in,
    output logic [LVL_N-1:0]  irq_lvl
);
    ctrl_wr_t          wr;
    ctrl_state_t       cst;
    logic [DATA_W-1:0] ctrl_q;
    logic [SRC_N-1:0]  pend;

    always_comb begin
        wr.wr   = bus_cs & bus_we;
        wr.data = bus_wdata;
    end

    lic_ctrl_reg u_ctrl (
        .clk (clk),
        .rst (rst),
        .wr  (wr),
        .st  (cst)
    );

    always_comb ctrl_q = cst.cur;
    always_comb bus_rdata = bus_cs ? ctrl_q : '0;

    lic_src_filter #(.N(SRC_N)) u_filt (
        .src_in (src_in),
        .pend   (pend)
    );

    // next-state enable keeps write-to-line latency at one edge
    lic_lvl_out #(.N(SRC_N), .L(LVL_N)) u_out (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend),
        .enable (cst.nxt[EN_BIT]),
        .irq_q  (irq_lvl)
    );
endmodule

// File: rtl/lic_checker.sv
module lic_checker
    import lic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_cs,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SRC_N-1:0]  src_in,
    input logic [LVL_N-1:0]  irq_lvl,
    input logic [DATA_W-1:0] ctrl_q
);
    p_reset_low_r1: assert property (@(posedge clk) rst |=> irq_lvl == '0);

    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_cs |-> bus_rdata == '0);

    p_bit6_clear_r3: assert property (@(posedge clk) disable iff (rst)
        bus_cs |-> !bus_rdata[6]);

    p_store_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && bus_we) |=> ctrl_q == ($past(bus_wdata) & WR_KEEP));

    p_line0_low_r10: assert property (@(posedge clk) disable iff (rst)
        !irq_lvl[0]);

    p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[EN_BIT] && !(bus_cs && bus_we)) |=> irq_lvl == '0);

    p_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[EN_BIT] && !(bus_cs && bus_we)) |=> irq_lvl[1] == $past(src_in[1]));

    p_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_cs |=> $stable(ctrl_q));
endmodule

bind lvl_irq_ctrl lic_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_cs    (bus_cs),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .irq_lvl   (irq_lvl),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module tb_lvl_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  src_in = 8'h00;
    logic [15:0] irq_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    lvl_irq_ctrl dut (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_lvl(irq_lvl)
    );

    function automatic int lvl_of(input int i);
        int t[8] = '{0, 1, 4, 6, 8, 10, 0, 14};
        return t[i];
    endfunction

    function automatic logic [15:0] expect_lines(input logic [7:0] s, input logic en);
        logic [15:0] e = '0;
        for (int i = 0; i < 8; i++)
            if (en && s[i] && lvl_of(i) != 0) e[lvl_of(i)] = 1'b1;
        return e;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic read_reg(output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0;
        #1 d = bus_rdata;
        bus_cs = 1'b0;
    endtask

    task automatic set_src(input logic [7:0] v);
        @(negedge clk);
        src_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        check("R1 lines", irq_lvl, 16'h0);
        read_reg(r);
        check("R1 ctrl", {8'h0, r}, 16'h0001);
    endtask

    task automatic t_bus();
        logic [7:0] r;
        @(negedge clk);
        #1 check("R2 idle rdata", {8'h0, bus_rdata}, 16'h0);
        write_reg(8'hFF);
        read_reg(r);
        check("R3 mask 0xFF", {8'h0, r}, 16'h00BF);
        write_reg(8'h40);
        read_reg(r);
        check("R3 bit6 only", {8'h0, r}, 16'h0000);
        write_reg(8'h5B);
        read_reg(r);
        check("R2 same-cycle read", {8'h0, r}, 16'h001B);
        write_reg(8'h01);
    endtask

    task automatic t_map();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            src_in = 8'h01 << i;
            #1 check("R9 before edge", irq_lvl, 16'h0);
            @(negedge clk);
            check($sformatf("R4 source %0d", i), irq_lvl, expect_lines(8'h01 << i, 1'b1));
            check("R10 line0", {15'h0, irq_lvl[0]}, 16'h0);
            set_src(8'h00);
        end
    endtask

    task automatic t_ignore();
        set_src(8'h41);
        check("R5 level-zero sources", irq_lvl, 16'h0);
        set_src(8'hFF);
        check("R7 all sources", irq_lvl, 16'h4552);
        set_src(8'hBE);
        check("R5 all but level-zero", irq_lvl, 16'h4552);
        set_src(8'h00);
    endtask

    task automatic t_level();
        set_src(8'h04);
        check("R6 held high", irq_lvl, 16'h0010);
        @(negedge clk);
        check("R6 still high", irq_lvl, 16'h0010);
        @(negedge clk);
        src_in = 8'h00;
        #1 check("R9 fall before edge", irq_lvl, 16'h0010);
        @(negedge clk);
        check("R6 dropped", irq_lvl, 16'h0);
    endtask

    task automatic t_enable();
        set_src(8'hFF);
        check("R7 enabled", irq_lvl, 16'h4552);
        write_reg(8'h00);
        check("R8 disabled", irq_lvl, 16'h0);
        set_src(8'h22);
        check("R8 held low", irq_lvl, 16'h0);
        write_reg(8'h01);
        check("R8 re-enabled tracks", irq_lvl, 16'h0402);
        set_src(8'h00);
    endtask

    task automatic t_no_cs();
        logic [7:0] r;
        set_src(8'h80);
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b1; bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 1'b0;
        check("R11 lines kept", irq_lvl, 16'h4000);
        read_reg(r);
        check("R11 ctrl kept", {8'h0, r}, 16'h0001);
        set_src(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bus();
        t_map();
        t_ignore();
        t_level();
        t_enable();
        t_no_cs();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule